// File: doc/BRIEF.md
# Synchronous Serial Shifter with Burst Length Control

This block is a clocked synchronous serial port. One start command runs a transfer whose length is set to the single bit, anywhere from 1 to 256 bits. Outgoing bytes are fetched from a one-entry transmit buffer and incoming bytes are handed out one at a time, so software or a streaming agent only has to keep pace at byte granularity. Bits may travel least-significant first or most-significant first.

The serial clock is either made locally or taken from a remote master. In local-clock mode an 8-bit reload divider sets each half period of the clock. In remote-clock mode the block follows the edges of an input pin. Outgoing data changes after each falling clock edge and incoming data is captured on each rising edge. At every byte boundary the engine can be held, with the clock parked high, and later released.

The data paths are valid/ready streams. A transmit byte is accepted on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` stays high while the one-entry buffer is empty. A receive byte is presented with `rx_valid`, and it is held stable until a cycle with `rx_ready` high. If that byte has not been taken when the next received byte completes, the engine stalls with the clock low until it is.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `sck_o` and `so_o` are 1, and `busy`, `done`, `rx_valid` and `byte_tick` are 0. `tx_ready` is 1.
- R2: In local-clock mode (`master`=1), each low phase and each high phase of `sck_o` lasts `div_reload`+1 clock cycles. `sck_o` is high whenever no bit is in flight.
- R3: `so_o` changes only in the cycle where `sck_o` falls. `si_i` is captured at the clock edge where `sck_o` rises.
- R4: With `lsb_first`=1, bit 0 of each transmit byte goes out first and received bits enter at bit 7 and shift right. With `lsb_first`=0, bit 7 goes out first and received bits enter at bit 0 and shift left.
- R5: A transfer carries `len_m1`+1 bits. When `single_byte`=1 it carries exactly 8 bits and `len_m1` has no effect.
- R6: `start` in idle raises `busy` and clears `done`. After the last bit, `busy` falls and `done` rises. A `start` while busy has no effect.
- R7: Each byte begins only when a transmit byte is buffered. Until then `sck_o` stays high and nothing shifts. Each full byte, and the final partial byte, appears on `rx_valid`/`rx_data` and is held until it is taken. A byte completion that would overwrite an untaken byte waits with `sck_o` low.
- R8: While `hold`=1 at a byte boundary, no new byte starts and `sck_o` stays high. Clearing `hold` resumes the transfer.
- R9: In a final byte of k<8 bits, the received bits are right-aligned when MSB-first and left-aligned when LSB-first. The unused positions read 0.
- R10: `byte_tick` pulses for one cycle after every eighth bit of a byte.
- R11: In remote-clock mode (`master`=0), a falling edge on `sck_in` shifts out a bit and a rising edge captures one. `sck_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | 1: local serial clock, 0: follow `sck_in` |
| lsb_first | input | 1 | Bit order select |
| single_byte | input | 1 | Force an 8-bit transfer |
| div_reload | input | 8 | Half-period reload value for the local clock |
| len_m1 | input | 8 | Transfer length minus one |
| start | input | 1 | Begin a transfer (pulse, idle only) |
| hold | input | 1 | Hold at the next byte boundary |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| byte_tick | output | 1 | One-cycle pulse after each full byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit buffer empty |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Received byte taken |
| rx_data | output | 8 | Received byte |
| sck_in | input | 1 | Remote serial clock |
| sck_o | output | 1 | Local serial clock |
| so_o | output | 1 | Serial data out |
| si_i | input | 1 | Serial data in |

## Verification
The bench targets several corner cases. One is lengths that end mid-byte in both bit orders. A design that mis-aligns that final byte would hand out shifted or stale bits. Another is the 256-bit maximum length, where a wrong counter load would stop one bit early or wrap to a zero-length transfer. The bench also starves the transmit buffer, holds at byte boundaries and withholds `rx_ready`. A design that ignored any of these would keep toggling `sck_o`, lose a byte or overwrite one. Finally, it repeats a transfer under a remote clock and pulses `start` mid-transfer, which would show up as an extra or restarted burst.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HIGH,
    ST_LOW
  } sio_state_e;
endpackage

// File: rtl/sio_txbuf.sv
module sio_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] byte_o
);
  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      byte_o <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (in_valid && !full) begin
      full   <= 1'b1;
      byte_o <= in_data;
    end
  end

  AST_TX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    full && !take |=> full && $stable(byte_o)); // R7
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic [DIV_W-1:0] div_reload,
  input  logic             restart,
  input  logic             run,
  input  logic             low_phase,
  input  logic             rise_block,
  input  logic             sck_in,
  output logic             fall_evt,
  output logic             rise_evt
);
  logic [DIV_W-1:0] cnt;
  logic             sck_prev;
  logic             zero;

  assign zero = (cnt == '0);

  always_comb begin
    if (master) begin
      fall_evt = run && !low_phase && zero;
      rise_evt = run && low_phase && zero;
    end else begin
      fall_evt = run && !low_phase && sck_prev && !sck_in;
      rise_evt = run && low_phase && !sck_prev && sck_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      sck_prev <= 1'b1;
    end else begin
      sck_prev <= sck_in;
      if (restart) begin
        cnt <= div_reload;
      end else if (run && master) begin
        if (!zero)
          cnt <= cnt - 1'b1;
        else if (!(low_phase && rise_block))
          cnt <= div_reload;
      end
    end
  end
endmodule

// File: rtl/sio_engine.sv
module sio_engine #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              lsb_first,
  input  logic              single_byte,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              start,
  input  logic              hold,
  input  logic              tx_full,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rx_ready,
  input  logic              si_i,
  input  logic              fall_evt,
  input  logic              rise_evt,
  output logic              take,
  output logic              run,
  output logic              low_phase,
  output logic              rise_block,
  output logic              busy,
  output logic              done,
  output logic              byte_tick,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck_o,
  output logic              so_o
);
  import sio_pkg::*;

  localparam int POS_W = $clog2(DATA_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(DATA_W - 1);
  localparam logic [LEN_W-1:0] BYTE_M1  = LEN_W'(DATA_W - 1);

  sio_state_e        state;
  logic [LEN_W-1:0]  left;
  logic [POS_W-1:0]  pos;
  logic [DATA_W-1:0] out_sr;
  logic [DATA_W-1:0] in_sr;
  logic [DATA_W-1:0] in_next;
  logic              completing;
  logic              do_rise;

  assign busy       = (state != ST_IDLE);
  assign run        = (state == ST_HIGH) || (state == ST_LOW);
  assign low_phase  = (state == ST_LOW);
  assign take       = (state == ST_WAIT) && !hold && tx_full;
  assign completing = (left == '0) || (pos == LAST_POS);
  assign rise_block = completing && rx_valid && !rx_ready;
  assign do_rise    = rise_evt && !rise_block;
  assign in_next    = lsb_first ? {si_i, in_sr[DATA_W-1:1]} : {in_sr[DATA_W-2:0], si_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      left      <= '0;
      pos       <= '0;
      out_sr    <= '0;
      in_sr     <= '0;
      done      <= 1'b0;
      byte_tick <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      sck_o     <= 1'b1;
      so_o      <= 1'b1;
    end else begin
      byte_tick <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          left  <= single_byte ? BYTE_M1 : len_m1;
          done  <= 1'b0;
          state <= ST_WAIT;
        end
        ST_WAIT: if (take) begin
          out_sr <= tx_byte;
          in_sr  <= '0;
          pos    <= '0;
          state  <= ST_HIGH;
        end
        ST_HIGH: if (fall_evt) begin
          sck_o  <= !master;
          so_o   <= lsb_first ? out_sr[0] : out_sr[DATA_W-1];
          out_sr <= lsb_first ? (out_sr >> 1) : (out_sr << 1);
          state  <= ST_LOW;
        end
        ST_LOW: if (do_rise) begin
          sck_o <= 1'b1;
          in_sr <= in_next;
          if (completing) begin
            rx_valid <= 1'b1;
            rx_data  <= in_next;
          end
          if (pos == LAST_POS) byte_tick <= 1'b1;
          if (left == '0) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            left <= left - 1'b1;
            if (pos == LAST_POS) begin
              state <= ST_WAIT;
            end else begin
              pos   <= pos + 1'b1;
              state <= ST_HIGH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_o); // R2
  AST_SO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    master && $past(master) && $past(sck_o) && sck_o |-> $stable(so_o)); // R3
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_tick |=> !byte_tick); // R10
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              lsb_first,
  input  logic              single_byte,
  input  logic [DIV_W-1:0]  div_reload,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              start,
  input  logic              hold,
  output logic              busy,
  output logic              done,
  output logic              byte_tick,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              sck_in,
  output logic              sck_o,
  output logic              so_o,
  input  logic              si_i
);
  logic              take;
  logic              tx_full;
  logic [DATA_W-1:0] tx_byte;
  logic              run;
  logic              low_phase;
  logic              rise_block;
  logic              fall_evt;
  logic              rise_evt;

  sio_txbuf #(.DATA_W(DATA_W)) u_txbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .in_data  (tx_data),
    .take     (take),
    .full     (tx_full),
    .byte_o   (tx_byte)
  );

  sio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .master     (master),
    .div_reload (div_reload),
    .restart    (take),
    .run        (run),
    .low_phase  (low_phase),
    .rise_block (rise_block),
    .sck_in     (sck_in),
    .fall_evt   (fall_evt),
    .rise_evt   (rise_evt)
  );

  sio_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .master      (master),
    .lsb_first   (lsb_first),
    .single_byte (single_byte),
    .len_m1      (len_m1),
    .start       (start),
    .hold        (hold),
    .tx_full     (tx_full),
    .tx_byte     (tx_byte),
    .rx_ready    (rx_ready),
    .si_i        (si_i),
    .fall_evt    (fall_evt),
    .rise_evt    (rise_evt),
    .take        (take),
    .run         (run),
    .low_phase   (low_phase),
    .rise_block  (rise_block),
    .busy        (busy),
    .done        (done),
    .byte_tick   (byte_tick),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .sck_o       (sck_o),
    .so_o        (so_o)
  );
endmodule

// File: tb/sync_shift_port_bench.sv
module sync_shift_port_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       master = 1'b1, lsb_first = 1'b0, single_byte = 1'b0;
  logic [7:0] div_reload = 8'd1, len_m1 = 8'd0;
  logic       start = 1'b0, hold = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h5A;
  logic       rx_ready = 1'b1;
  logic       sck_in = 1'b1;
  logic       si_i = 1'b0;
  logic       busy, done, byte_tick, tx_ready, rx_valid, sck_o, so_o;
  logic [7:0] rx_data;

  sync_shift_port u_sync_shift_port (
    .clk(clk), .rst_n(rst_n), .master(master), .lsb_first(lsb_first),
    .single_byte(single_byte), .div_reload(div_reload), .len_m1(len_m1),
    .start(start), .hold(hold), .busy(busy), .done(done), .byte_tick(byte_tick),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sck_in(sck_in), .sck_o(sck_o), .so_o(so_o), .si_i(si_i)
  );

  int checks = 0, errors = 0, cyc = 0, falls = 0;
  bit feed_on = 0, si_force = 0, slv_on = 0, tx_hs = 0, sck_seen = 1;
  logic [7:0] last_rx = 8'h00;
  logic [15:0] lfsr = 16'hACE1;
  int scnt = 0;

  // reference model state
  int m_st = 0, m_timer = 0, m_left = 0, m_pos = 0;
  logic [7:0] m_out = 0, m_in = 0;
  bit m_sck = 1, m_so = 1, m_done = 0, m_tick = 0, m_prev = 1;
  bit pre_rx, pre_tx, ev, fin, blk;
  logic [7:0] txq[$], rxq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    tx_hs = tx_valid && tx_ready;
    if (rx_valid && rx_ready) last_rx = rx_data;
    if (!rst_n) begin
      m_st = 0; m_timer = 0; m_left = 0; m_pos = 0; m_out = 0; m_in = 0;
      m_sck = 1; m_so = 1; m_done = 0; m_tick = 0; m_prev = 1;
      txq.delete(); rxq.delete();
    end else begin
      pre_rx = rxq.size() != 0;
      pre_tx = txq.size() != 0;
      if (rx_ready && pre_rx) void'(rxq.pop_front());
      m_tick = 0;
      case (m_st)
        0: if (start) begin
          m_left = single_byte ? 7 : int'(len_m1);
          m_done = 0; m_st = 1;
        end
        1: if (!hold && pre_tx) begin
          m_out = txq.pop_front(); m_in = 0; m_pos = 0;
          m_timer = int'(div_reload); m_st = 2;
        end
        2: begin
          ev = master ? (m_timer == 0) : (m_prev && !sck_in);
          if (master) m_timer = (m_timer == 0) ? int'(div_reload) : m_timer - 1;
          if (ev) begin
            m_sck = !master;
            m_so = lsb_first ? m_out[0] : m_out[7];
            m_out = lsb_first ? (m_out >> 1) : (m_out << 1);
            m_st = 3;
          end
        end
        default: begin
          fin = (m_left == 0) || (m_pos == 7);
          blk = fin && pre_rx && !rx_ready;
          ev = master ? (m_timer == 0) : (!m_prev && sck_in);
          if (master) begin
            if (m_timer != 0) m_timer = m_timer - 1;
            else if (!blk) m_timer = int'(div_reload);
          end
          if (ev && !blk) begin
            m_sck = 1;
            m_in = lsb_first ? {si_i, m_in[7:1]} : {m_in[6:0], si_i};
            if (fin) rxq.push_back(m_in);
            if (m_pos == 7) m_tick = 1;
            if (m_left == 0) begin
              m_done = 1; m_st = 0;
            end else begin
              m_left--;
              if (m_pos == 7) m_st = 1;
              else begin m_pos++; m_st = 2; end
            end
          end
        end
      endcase
      m_prev = sck_in;
      if (tx_valid && !pre_tx) txq.push_back(tx_data);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(sck_o === (master ? m_sck : 1'b1), "R2 sck_o", sck_o, master ? m_sck : 1'b1);
      check(so_o === m_so, "R4 so_o", so_o, m_so);
      check(busy === (m_st != 0), "R6 busy", busy, m_st != 0);
      check(done === m_done, "R6 done", done, m_done);
      check(byte_tick === m_tick, "R10 byte_tick", byte_tick, m_tick);
      check(tx_ready === (txq.size() == 0), "R7 tx_ready", tx_ready, txq.size() == 0);
      check(rx_valid === (rxq.size() != 0), "R7 rx_valid", rx_valid, rxq.size() != 0);
      if (rxq.size() != 0) check(rx_data === rxq[0], "R9 rx_data", rx_data, rxq[0]);
      if (master && sck_seen && !sck_o) falls++;
      sck_seen = sck_o;
    end
  end

  // stimulus sources
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    si_i = si_force ? 1'b1 : lfsr[0];
    if (feed_on) begin
      if (tx_hs) tx_data = tx_data + 8'h37;
      tx_valid = 1'b1;
    end else tx_valid = 1'b0;
    if (slv_on) begin
      scnt++;
      if (scnt == 3) begin scnt = 0; sck_in = ~sck_in; end
    end else begin
      scnt = 0; sck_in = 1'b1;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    check(!busy, "R6 transfer ends", busy, 0);
  endtask

  task automatic xfer(input bit mst, input bit lsb, input bit sgl,
                      input logic [7:0] dv, input logic [7:0] lm1, input int nbits);
    int base;
    master = mst; lsb_first = lsb; single_byte = sgl; div_reload = dv; len_m1 = lm1;
    base = falls;
    pulse_start();
    wait_idle();
    @(negedge clk);
    check(done === 1'b1, "R6 done after transfer", done, 1);
    if (mst) check(falls - base == nbits, "R5 bit count", falls - base, nbits);
  endtask

  initial begin
    int base;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sck_o === 1'b1 && so_o === 1'b1, "R1 pins idle", {sck_o, so_o}, 2'b11);
    check(!busy && !done && !rx_valid && !byte_tick, "R1 status clear",
          {busy, done, rx_valid, byte_tick}, 0);
    check(tx_ready === 1'b1, "R1 tx_ready", tx_ready, 1);

    // starved transmit buffer: must wait with clock high
    master = 1; lsb_first = 0; div_reload = 8'd1; len_m1 = 8'd15;
    base = falls;
    pulse_start();
    repeat (20) @(negedge clk);
    check(busy && sck_o && (falls == base), "R7 waits for tx byte", falls - base, 0);
    feed_on = 1;
    wait_idle();
    check(falls - base == 16, "R5 16 bits", falls - base, 16);

    // partial final bytes, both orders
    si_force = 1;
    xfer(1, 1, 0, 8'd0, 8'd4, 5);
    repeat (3) @(negedge clk);
    check(last_rx === 8'hF8, "R9 lsb-first partial left-aligned", last_rx, 8'hF8);
    xfer(1, 0, 0, 8'd0, 8'd2, 3);
    repeat (3) @(negedge clk);
    check(last_rx === 8'h07, "R9 msb-first partial right-aligned", last_rx, 8'h07);
    si_force = 0;

    // hold at start and at a mid-transfer byte boundary
    master = 1; lsb_first = 0; single_byte = 0; div_reload = 8'd2; len_m1 = 8'd23;
    hold = 1; base = falls;
    pulse_start();
    repeat (30) @(negedge clk);
    check(busy && sck_o && (falls == base), "R8 held at first boundary", falls - base, 0);
    hold = 0;
    n = 0;
    while (!byte_tick && n < 5000) begin @(negedge clk); n++; end
    hold = 1;
    n = falls;
    repeat (25) @(negedge clk);
    check(sck_o && busy && (falls == n), "R8 held mid transfer", falls - n, 0);
    hold = 0;
    wait_idle();
    check(falls - base == 24, "R8 resumed to full length", falls - base, 24);

    // fixed 8-bit mode ignores len_m1
    xfer(1, 1, 1, 8'd1, 8'd2, 8);

    // maximum length with an ignored start in the middle
    master = 1; lsb_first = 0; single_byte = 0; div_reload = 8'd0; len_m1 = 8'd255;
    base = falls;
    pulse_start();
    repeat (50) @(negedge clk);
    pulse_start();
    wait_idle();
    check(falls - base == 256, "R6 start while busy ignored, R5 256 bits", falls - base, 256);

    // receive back-pressure
    rx_ready = 0;
    master = 1; lsb_first = 1; div_reload = 8'd0; len_m1 = 8'd15;
    pulse_start();
    n = 0;
    while (!rx_valid && n < 5000) begin @(negedge clk); n++; end
    repeat (40) @(negedge clk);
    check(busy && rx_valid, "R7 stalls on untaken rx byte", {busy, rx_valid}, 2'b11);
    rx_ready = 1;
    wait_idle();

    // remote clock
    master = 0; lsb_first = 1; len_m1 = 8'd11;
    slv_on = 1;
    pulse_start();
    wait_idle();
    @(negedge clk);
    check(done === 1'b1 && sck_o === 1'b1, "R11 remote clock transfer", {done, sck_o}, 2'b11);
    slv_on = 0;
    repeat (10) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule